// File: doc/BRIEF.md
# Timed Event Scheduler

This block holds up to eight pending timed commands and carries each one out when a free-running timer reaches the time stored with it. The host writes a command: a 16-bit target time, a 4-bit action code, a timer-select bit, an interrupt-enable bit and a level bit. The command goes into the lowest free slot of an eight-entry associative store. Both timers come in as inputs. The block never counts time itself.

At the start of every pass, the block copies both timers into snapshot registers. A pass lasts `DEPTH` cycles. During the pass a scan pointer visits slots 0 through `DEPTH-1`, one slot per cycle, and compares the stored time with the snapshot of the timer that slot selects. On an exact match the slot is freed. One cycle later the block drives one of six output lines, sets one of four sticky software flags, pulses a timer-B clear or pulses a conversion start. It can also pulse one of two interrupt lines.

Top module: `event_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the store is empty, `store_full` is 0, and every output line, flag, strobe and interrupt output is 0.
- R2: When `wr_en` is high and the store is not full, the command is placed in the lowest-numbered free slot. `store_full` goes high in the cycle after the edge that fills the last free slot.
- R3: A command written while `store_full` is high is dropped and never executes.
- R4: A stored command fires only when its time is exactly equal to the selected timer (`wr_tsel`=0 selects `timer_a`, `wr_tsel`=1 selects `timer_b`). A value one above or one below the stored time does nothing, and so does a match on the other timer.
- R5: Action codes 0 to 5 drive `out_lines[code]` to the command's level bit.
- R6: Action codes 8 to 11 set `sw_flags[code-8]`. A flag stays set until reset.
- R7: Action code 12 produces a one-cycle pulse on `timer_b_clr`, and code 13 produces a one-cycle pulse on `conv_start`. Codes 6, 7, 14 and 15 free their slot and have no effect.
- R8: When the interrupt bit is set, codes 0 to 5, 12 and 13 pulse `irq_exec` for one cycle in the same cycle as the action, and codes 8 to 11 pulse `irq_soft` for one cycle in the same way. When the interrupt bit is clear, no interrupt output pulses.
- R9: A command that fires frees its slot and executes exactly once.
- R10: The timers are sampled once at the start of each pass of `DEPTH` cycles. Commands that match in the same pass execute one per cycle in ascending slot order. A command whose time equals a timer value that stays steady executes within 2*`DEPTH`+2 cycles of that value first appearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_time | input | 16 | Target time of the command |
| wr_code | input | 4 | Action code |
| wr_tsel | input | 1 | Reference timer: 0 = timer_a, 1 = timer_b |
| wr_irq | input | 1 | Raise an interrupt when the command executes |
| wr_level | input | 1 | Level driven by output-line commands |
| timer_a | input | 16 | First reference timer |
| timer_b | input | 16 | Second reference timer |
| store_full | output | 1 | All slots occupied |
| out_lines | output | 6 | Scheduled output lines |
| sw_flags | output | 4 | Sticky software-timer flags |
| timer_b_clr | output | 1 | One-cycle request to clear timer B |
| conv_start | output | 1 | One-cycle request to start a conversion |
| irq_exec | output | 1 | Execution interrupt pulse |
| irq_soft | output | 1 | Software-timer interrupt pulse |

## Verification
`store_full` reflects a write one cycle after the accepting edge, so the bench reads it at the falling edge that follows the write strobe. An action becomes visible one cycle after its slot is scanned. That can come anywhere from one to 2*`DEPTH`+1 cycles after a timer change, depending on where the scan stands. For this reason the monitor does not expect actions in fixed cycles. It samples 1 ns after each rising edge, turns every visible change into an event, and matches each event against an ordered queue of expected events, which checks the slot order. The drain step checks that the queue empties within the 2*`DEPTH`+2 bound. Non-matching and dropped commands are checked by waiting well past that bound, confirming that the queue has not moved, and relying on the monitor to flag any unexpected event.

// File: rtl/sched_pkg.sv
// Shared types and action encodings for the timed event scheduler.
// Assumes a 4-bit action code; time width is set here once for all modules.
package sched_pkg;
    parameter int TIME_W = 16;
    parameter int CODE_W = 4;

    // One stored command.
    typedef struct packed {
        logic [TIME_W-1:0] t;
        logic [CODE_W-1:0] code;
        logic              tsel;
        logic              irq;
        logic              level;
    } cmd_t;

    localparam logic [CODE_W-1:0] CODE_TB_CLR = 4'd12;
    localparam logic [CODE_W-1:0] CODE_CONV   = 4'd13;
endpackage

// File: rtl/cmd_store.sv
// Command store: valid bits plus entry storage, lowest-free-slot allocation.
// Assumes the freed slot (a valid one) never equals the allocated slot (a free one).
module cmd_store #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  sched_pkg::cmd_t      wr_cmd,
    input  logic                 free_en,
    input  logic [IW-1:0]        free_idx,
    output logic [DEPTH-1:0]     valid,
    output sched_pkg::cmd_t      ents [DEPTH],
    output logic                 full
);
    logic [IW-1:0] alloc;

    assign full = &valid;

    // Pick the lowest-numbered free slot.
    always_comb begin
        alloc = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) alloc = IW'(i);
        end
    end

    // Track occupancy: set on accepted write, clear on execution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else begin
            if (free_en) valid[free_idx] <= 1'b0;
            if (wr_en && !full) valid[alloc] <= 1'b1;
        end
    end

    // Capture the command contents into the allocated slot.
    always_ff @(posedge clk) begin
        if (wr_en && !full) ents[alloc] <= wr_cmd;
    end

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !free_en) |=> $stable(valid));

    // R9
    freed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |=> !valid[$past(free_idx)]);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> (valid != '0));
endmodule

// File: rtl/scan_unit.sv
// Scan pointer and comparator: walks one slot per cycle, compares against
// timer snapshots taken at each pass start (the edge leaving the last slot).
// Assumes the snapshots reset to zero, so the first pass compares against time 0.
module scan_unit #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int TW = sched_pkg::TIME_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        timer_a,
    input  logic [TW-1:0]        timer_b,
    input  logic [DEPTH-1:0]     valid,
    input  sched_pkg::cmd_t      ents [DEPTH],
    output logic                 hit,
    output logic [IW-1:0]        ptr,
    output sched_pkg::cmd_t      hit_cmd
);
    logic [TW-1:0] snap_a, snap_b, ref_t;
    logic          last_slot;

    assign last_slot = (ptr == IW'(DEPTH - 1));

    // Advance the pointer and refresh the snapshots at every pass boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            snap_a <= '0;
            snap_b <= '0;
        end else begin
            ptr <= last_slot ? '0 : ptr + 1'b1;
            if (last_slot) begin
                snap_a <= timer_a;
                snap_b <= timer_b;
            end
        end
    end

    // Exact-equality compare of the current slot against its chosen snapshot.
    always_comb begin
        hit_cmd = ents[ptr];
        ref_t   = hit_cmd.tsel ? snap_b : snap_a;
        hit     = valid[ptr] && (hit_cmd.t == ref_t);
    end

    // R10
    snap_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_a) |-> ($past(ptr) == IW'(DEPTH - 1)));
endmodule

// File: rtl/action_unit.sv
// Action decoder: turns a matched command into line, flag, strobe and
// interrupt outputs one cycle later. Assumes at most one hit per cycle.
module action_unit #(
    parameter int NLINES = 6,
    parameter int NFLAGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  sched_pkg::cmd_t      cmd,
    output logic [NLINES-1:0]    lines,
    output logic [NFLAGS-1:0]    flags,
    output logic                 tb_clr,
    output logic                 conv,
    output logic                 irq_exec,
    output logic                 irq_soft
);
    logic is_line, is_flag;

    // Classify the action code.
    always_comb begin
        is_line = (cmd.code[3] == 1'b0) && (int'(cmd.code[2:0]) < NLINES);
        is_flag = (cmd.code[3:2] == 2'b10) && (int'(cmd.code[1:0]) < NFLAGS);
    end

    // Apply the action and emit one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines    <= '0;
            flags    <= '0;
            tb_clr   <= 1'b0;
            conv     <= 1'b0;
            irq_exec <= 1'b0;
            irq_soft <= 1'b0;
        end else begin
            tb_clr   <= 1'b0;
            conv     <= 1'b0;
            irq_exec <= 1'b0;
            irq_soft <= 1'b0;
            if (hit) begin
                for (int i = 0; i < NLINES; i++) begin
                    if (is_line && cmd.code[2:0] == 3'(i)) lines[i] <= cmd.level;
                end
                for (int j = 0; j < NFLAGS; j++) begin
                    if (is_flag && cmd.code[1:0] == 2'(j)) flags[j] <= 1'b1;
                end
                if (cmd.code == sched_pkg::CODE_TB_CLR) tb_clr <= 1'b1;
                if (cmd.code == sched_pkg::CODE_CONV)   conv   <= 1'b1;
                irq_exec <= cmd.irq && (is_line || cmd.code == sched_pkg::CODE_TB_CLR
                                        || cmd.code == sched_pkg::CODE_CONV);
                irq_soft <= cmd.irq && is_flag;
            end
        end
    end

    // R8
    one_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_exec, irq_soft}));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_exec || irq_soft) |-> $past(hit));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/event_sched.sv
// Top of the timed event scheduler: store, scanner and action decoder.
// Assumes DEPTH is a power of two and the timers are synchronous to clk.
module event_sched #(
    parameter int DEPTH  = 8,
    parameter int NLINES = 6,
    parameter int NFLAGS = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int TW = sched_pkg::TIME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TW-1:0]     wr_time,
    input  logic [3:0]        wr_code,
    input  logic              wr_tsel,
    input  logic              wr_irq,
    input  logic              wr_level,
    input  logic [TW-1:0]     timer_a,
    input  logic [TW-1:0]     timer_b,
    output logic              store_full,
    output logic [NLINES-1:0] out_lines,
    output logic [NFLAGS-1:0] sw_flags,
    output logic              timer_b_clr,
    output logic              conv_start,
    output logic              irq_exec,
    output logic              irq_soft
);
    sched_pkg::cmd_t  wr_cmd, hit_cmd;
    sched_pkg::cmd_t  ents [DEPTH];
    logic [DEPTH-1:0] valid;
    logic             hit;
    logic [IW-1:0]    ptr;

    // Pack the write fields into one command word.
    always_comb begin
        wr_cmd = '{t: wr_time, code: wr_code, tsel: wr_tsel, irq: wr_irq, level: wr_level};
    end

    cmd_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .free_en(hit), .free_idx(ptr), .valid(valid), .ents(ents), .full(store_full)
    );

    scan_unit #(.DEPTH(DEPTH)) u_scan (
        .clk(clk), .rst_n(rst_n), .timer_a(timer_a), .timer_b(timer_b),
        .valid(valid), .ents(ents), .hit(hit), .ptr(ptr), .hit_cmd(hit_cmd)
    );

    action_unit #(.NLINES(NLINES), .NFLAGS(NFLAGS)) u_act (
        .clk(clk), .rst_n(rst_n), .hit(hit), .cmd(hit_cmd),
        .lines(out_lines), .flags(sw_flags), .tb_clr(timer_b_clr), .conv(conv_start),
        .irq_exec(irq_exec), .irq_soft(irq_soft)
    );
endmodule

// File: tb/event_sched_test.sv
`timescale 1ns/1ps
module event_sched_test;
    localparam int DEPTH = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wr_time = '0;
    logic [3:0] wr_code = '0;
    logic wr_tsel = 1'b0, wr_irq = 1'b0, wr_level = 1'b0;
    logic [15:0] timer_a = 16'h0100, timer_b = 16'h0000;
    logic store_full;
    logic [5:0] out_lines;
    logic [3:0] sw_flags;
    logic timer_b_clr, conv_start, irq_exec, irq_soft;

    int compared = 0, mismatched = 0;
    bit mon_on = 1'b0;
    logic [8:0] expq [$];

    event_sched uut (.*);

    always #2 clk = ~clk;

    // Event word: {irq_exec, irq_soft, kind[2:0], idx[2:0], level}; kind 1 line, 2 flag, 3 clr, 4 conv.
    function automatic logic [8:0] exp_ev(input logic [3:0] code, input logic irq, input logic lvl);
        if (code < 4'd6)        return {irq, 1'b0, 3'd1, code[2:0], lvl};
        else if (code[3:2] == 2'b10) return {1'b0, irq, 3'd2, 1'b0, code[1:0], 1'b0};
        else if (code == 4'd12) return {irq, 1'b0, 3'd3, 3'd0, 1'b0};
        else                    return {irq, 1'b0, 3'd4, 3'd0, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: write one command and queue its expected event unless it is to be dropped.
    task automatic put(input logic [15:0] t, input logic [3:0] c, input logic ts,
                       input logic irq, input logic lvl, input bit expect_it);
        @(negedge clk);
        wr_en = 1'b1; wr_time = t; wr_code = c; wr_tsel = ts; wr_irq = irq; wr_level = lvl;
        @(negedge clk);
        wr_en = 1'b0;
        if (expect_it) expq.push_back(exp_ev(c, irq, lvl));
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (expq.size() != 0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n <= 2*DEPTH + 2 && expq.size() == 0, req, n, 2*DEPTH + 2);
    endtask

    task automatic idle(input int cyc, input int qexp, input string req);
        repeat (cyc) @(negedge clk);
        check(expq.size() == qexp, req, expq.size(), qexp);
    endtask

    // Monitor: turn visible output changes into events and compare in order.
    initial begin
        logic [5:0] pl;
        logic [3:0] pf;
        logic [8:0] ev;
        pl = '0; pf = '0;
        forever begin
            @(posedge clk); #1;
            if (mon_on) begin
                ev = '0;
                for (int i = 0; i < 6; i++)
                    if (out_lines[i] != pl[i]) ev = {1'b0, 1'b0, 3'd1, 3'(i), out_lines[i]};
                for (int j = 0; j < 4; j++)
                    if (sw_flags[j] && !pf[j]) ev = {1'b0, 1'b0, 3'd2, 1'b0, 2'(j), 1'b0};
                if (timer_b_clr) ev[6:4] = 3'd3;
                if (conv_start)  ev[6:4] = 3'd4;
                ev[8] = irq_exec; ev[7] = irq_soft;
                if (ev != '0) begin
                    if (expq.size() == 0) check(1'b0, "R9 unexpected event", ev, 0);
                    else begin
                        logic [8:0] e;
                        e = expq.pop_front();
                        check(ev == e, "R5/R6/R7/R8/R10 event", ev, e);
                    end
                end
            end
            pl = out_lines; pf = sw_flags;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(store_full == 1'b0 && out_lines == '0 && sw_flags == '0, "R1 reset", {store_full, out_lines, sw_flags}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({store_full, out_lines, sw_flags, timer_b_clr, conv_start, irq_exec, irq_soft} == '0,
              "R1 after release", {store_full, out_lines, sw_flags}, 0);
        mon_on = 1'b1;

        // R10: same-pass matches run in slot order; R5/R6/R7/R8 mixed actions
        put(16'h0200, 4'd9, 1'b0, 1'b1, 1'b0, 1);
        put(16'h0200, 4'd2, 1'b0, 1'b1, 1'b1, 1);
        put(16'h0200, 4'd0, 1'b0, 1'b0, 1'b1, 1);
        put(16'h0200, 4'd13, 1'b0, 1'b1, 1'b0, 1);
        idle(3 * DEPTH, 4, "R4 no early fire");
        @(negedge clk) timer_a = 16'h0200;
        drain("R10 order and latency");
        check(out_lines == 6'b000101, "R5 lines", out_lines, 6'b000101);

        // R4: timer select
        put(16'h0300, 4'd3, 1'b1, 1'b1, 1'b1, 1);
        @(negedge clk) timer_a = 16'h0300;
        idle(3 * DEPTH, 1, "R4 other timer ignored");
        @(negedge clk) begin timer_a = 16'h0100; timer_b = 16'h0300; end
        drain("R4 selected timer fires");

        // R4: exact equality, R8 no interrupt when bit clear
        put(16'h0500, 4'd8, 1'b0, 1'b0, 1'b0, 1);
        @(negedge clk) timer_a = 16'h04FF;
        idle(3 * DEPTH, 1, "R4 one below");
        @(negedge clk) timer_a = 16'h0501;
        idle(3 * DEPTH, 1, "R4 one above");
        @(negedge clk) timer_a = 16'h0500;
        drain("R4 exact match");
        check(sw_flags == 4'b0011, "R6 flags", sw_flags, 4'b0011);

        // R2/R3/R9: fill, drop, drain
        @(negedge clk) timer_a = 16'h0100;
        put(16'h0400, 4'd0, 1'b0, 1'b1, 1'b0, 1);
        put(16'h0400, 4'd2, 1'b0, 1'b0, 1'b0, 1);
        put(16'h0400, 4'd3, 1'b0, 1'b1, 1'b0, 1);
        put(16'h0400, 4'd1, 1'b0, 1'b0, 1'b1, 1);
        put(16'h0400, 4'd4, 1'b0, 1'b1, 1'b1, 1);
        put(16'h0400, 4'd5, 1'b0, 1'b0, 1'b1, 1);
        put(16'h0400, 4'd12, 1'b0, 1'b1, 1'b0, 1);
        check(store_full == 1'b0, "R2 seven stored", store_full, 0);
        put(16'h0400, 4'd10, 1'b0, 1'b1, 1'b0, 1);
        check(store_full == 1'b1, "R2 full after eighth", store_full, 1);
        put(16'h0400, 4'd11, 1'b0, 1'b1, 1'b0, 0);
        check(store_full == 1'b1, "R3 still full", store_full, 1);
        @(negedge clk) timer_a = 16'h0400;
        drain("R10 full drain order");
        idle(4 * DEPTH, 0, "R9 executed once");
        check(store_full == 1'b0, "R9 slots freed", store_full, 0);
        check(sw_flags == 4'b0111, "R3 dropped flag stays clear / R6", sw_flags, 4'b0111);
        check(out_lines == 6'b110010, "R5 final lines", out_lines, 6'b110010);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule